// File: doc/BRIEF.md
# Masked Pending Interrupt Controller

This block gathers interrupt events from one timer and from a set of serial-port style sources, and keeps them in a 32-bit pending register. A 32-bit mask register sits next to it. Both registers are reached over a simple single-cycle register bus. Each source has a fixed interrupt number that is set by a parameter. When a source is recorded, the bit at that number in the pending register goes high. Software acknowledges an interrupt by writing the pending register.

In any cycle, at most one request is considered, chosen by a fixed priority. The timer comes first. Next come the serial sources, lowest index first. Inside one serial source, a transmit-empty request beats a receive-data request. The chosen request is recorded only if its source is unmasked and its pending bit is still clear. If it is not recorded, it is dropped; a lower-priority request does not get that cycle instead. Each source gets an acknowledge pulse in the same cycle its request is recorded, so the source can update its own identity state. A single line to the CPU is high while some pending bit is set and not masked.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xFFFFFFFF, the pending register reads 0x00000000, and `cpu_irq` is low.
- R2: A bus read at byte offset 0x0 returns the mask register, and at offset 0x4 returns the pending register. A read at any other offset returns zero. A write to offset 0x0 replaces the mask register. A write to any other offset except 0x4 changes neither register.
- R3: A selected request is dropped if the mask bit at its ID is 1 or the pending bit at its ID is already 1. When a request is dropped, no acknowledge is raised and the pending register does not change.
- R4: A selected request that is not dropped raises its acknowledge in the same cycle. The pending bit at its ID reads as 1 after the next clock edge. The default IDs are: timer 3, serial source 0 is 8, serial source 1 is 9.
- R5: A write to offset 0x4 replaces all 32 pending bits with the write data. Writing a bit as 0 clears it.
- R6: While `tmr_req` is high, no serial request is acknowledged or recorded, and at most one acknowledge is high in any cycle.
- R7: Among serial sources, the one with the lowest index that has any request is selected, and higher-index sources are ignored.
- R8: Within one serial source, `tx_req` is selected over `rx_req` when both are high.
- R9: If the selected request is dropped, no other source is recorded in that cycle, even if its own mask and pending bits would allow it.
- R10: `cpu_irq` equals the OR over all bits of (pending AND NOT mask).
- R11: If a pending-register write and a recorded request fall in the same cycle, the result is the write data with the recorded ID's bit set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tmr_req | input | 1 | Timer event request |
| tx_req | input | NUM_UART | Transmit-empty request, one bit per serial source |
| rx_req | input | NUM_UART | Receive-data request, one bit per serial source |
| tmr_ack | output | 1 | Timer request recorded this cycle |
| tx_ack | output | NUM_UART | Transmit-empty request recorded this cycle |
| rx_ack | output | NUM_UART | Receive-data request recorded this cycle |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
Several kinds of request patterns are applied, and each one separates a different part of the logic:
- A single lone request is sent while its source is masked, then unmasked, then already pending. This tests the recording condition on its own.
- Requests are made to collide: timer with serial sources, a low-index serial source with a high-index one, and transmit with receive inside one source. This exposes any error in priority order.
- The selected source is blocked while a lower-priority source is free. This tells apart strict single-winner arbitration from a design that falls through to the next source.
- A pending-register write is made in the same cycle as a recorded event. This shows which of the two wins on that bit.

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int NUM_UART = 2,
  parameter int ID_W = 5,
  parameter int ADDR_W = 8,
  parameter int TIMER_ID = 3,
  parameter logic [NUM_UART*ID_W-1:0] UART_IDS = {5'd9, 5'd8}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                tmr_req,
  input  logic [NUM_UART-1:0] tx_req,
  input  logic [NUM_UART-1:0] rx_req,
  output logic                tmr_ack,
  output logic [NUM_UART-1:0] tx_ack,
  output logic [NUM_UART-1:0] rx_ack,
  output logic                cpu_irq
);
  localparam logic [ID_W-1:0]   TID      = ID_W'(TIMER_ID);
  localparam logic [ADDR_W-1:0] MASK_OFF = '0;
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'(4);

  logic [31:0] mask_q, pend_q, pend_d;
  logic [ID_W-1:0] win_id;
  logic hit, accept, sel_tmr;
  logic [NUM_UART-1:0] sel_tx, sel_rx;

  wire wr_mask = bus_sel && bus_wr && (bus_addr == MASK_OFF);
  wire wr_pend = bus_sel && bus_wr && (bus_addr == PEND_OFF);

  always_comb begin
    hit = 1'b0;
    win_id = TID;
    sel_tmr = 1'b0;
    sel_tx = '0;
    sel_rx = '0;
    if (tmr_req) begin
      hit = 1'b1;
      sel_tmr = 1'b1;
    end else begin
      for (int i = 0; i < NUM_UART; i++) begin
        if (!hit && (tx_req[i] || rx_req[i])) begin
          hit = 1'b1;
          win_id = UART_IDS[i*ID_W +: ID_W];
          if (tx_req[i]) sel_tx[i] = 1'b1;
          else           sel_rx[i] = 1'b1;
        end
      end
    end
  end

  assign accept  = hit && !mask_q[win_id] && !pend_q[win_id];
  assign tmr_ack = sel_tmr && accept;
  assign tx_ack  = sel_tx & {NUM_UART{accept}};
  assign rx_ack  = sel_rx & {NUM_UART{accept}};

  always_comb begin
    pend_d = wr_pend ? bus_wdata : pend_q;
    if (accept) pend_d[win_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata;
      pend_q <= pend_d;
    end
  end

  assign bus_rdata = (bus_addr == MASK_OFF) ? mask_q :
                     (bus_addr == PEND_OFF) ? pend_q : 32'h0;
  assign cpu_irq = |(pend_q & ~mask_q);

  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_ack, tx_ack, rx_ack}));
  a_r6_timer_first: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req |-> (tx_ack == '0 && rx_ack == '0));
  a_r4_timer_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ack |=> pend_q[TID]);
  a_r3_dropped_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend && !tmr_ack && tx_ack == '0 && rx_ack == '0) |=> $stable(pend_q));

  for (genvar g = 0; g < NUM_UART; g++) begin : g_chk
    localparam logic [NUM_UART-1:0] LOWER = NUM_UART'((1 << g) - 1);
    a_r8_tx_first: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req[g] |-> !rx_ack[g]);
    a_r7_low_index: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack[g] || rx_ack[g]) |-> (!tmr_req && ((tx_req | rx_req) & LOWER) == '0));
  end
endmodule

// File: tb/irq_pend_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tmr_req = 0;
  logic [1:0] tx_req = 0, rx_req = 0, tx_ack, rx_ack;
  logic tmr_ack, cpu_irq;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_pend_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_req(tmr_req), .tx_req(tx_req), .rx_req(rx_req),
    .tmr_ack(tmr_ack), .tx_ack(tx_ack), .rx_ack(rx_ack), .cpu_irq(cpu_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  // ack vector: {tmr, tx1, tx0, rx1, rx0}
  task automatic pulse(input logic t, input logic [1:0] tx, input logic [1:0] rx,
                       input logic [4:0] exp_ack, input string tag);
    @(negedge clk);
    tmr_req = t; tx_req = tx; rx_req = rx;
    #1 chk(tag, {27'h0, tmr_ack, tx_ack, rx_ack}, {27'h0, exp_ack});
    @(negedge clk);
    tmr_req = 0; tx_req = 0; rx_req = 0;
  endtask

  task automatic t_reset;
    rd(8'h0, 32'hFFFF_FFFF, "R1 mask reset");
    rd(8'h4, 32'h0, "R1 pend reset");
    chk("R1 irq reset", {31'h0, cpu_irq}, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h0, 32'h1234_5678);
    rd(8'h0, 32'h1234_5678, "R2 mask readback");
    wr(8'h8, 32'hDEAD_BEEF);
    rd(8'h8, 32'h0, "R2 other offset reads zero");
    rd(8'h0, 32'h1234_5678, "R2 stray write ignored mask");
    rd(8'h4, 32'h0, "R2 stray write ignored pend");
  endtask

  task automatic t_record;
    wr(8'h0, 32'h0000_0008);
    pulse(1, 0, 0, 5'b00000, "R3 masked timer no ack");
    rd(8'h4, 32'h0, "R3 masked timer pend unchanged");
    wr(8'h0, 32'h0);
    pulse(1, 0, 0, 5'b10000, "R4 timer ack");
    rd(8'h4, 32'h8, "R4 timer bit 3");
    chk("R10 irq high", {31'h0, cpu_irq}, 32'h1);
    pulse(1, 0, 0, 5'b00000, "R3 already pending no ack");
    rd(8'h4, 32'h8, "R3 pend unchanged");
    wr(8'h0, 32'h8);
    #1 chk("R10 irq masked", {31'h0, cpu_irq}, 32'h0);
    wr(8'h0, 32'h0);
    wr(8'h4, 32'h0);
    rd(8'h4, 32'h0, "R5 clear pend");
    wr(8'h4, 32'hF0F0_0000);
    rd(8'h4, 32'hF0F0_0000, "R5 replace pend");
    wr(8'h4, 32'h0);
  endtask

  task automatic t_prio;
    pulse(1, 2'b01, 2'b10, 5'b10000, "R6 timer beats serial");
    rd(8'h4, 32'h8, "R6 only timer recorded");
    wr(8'h4, 32'h0);
    pulse(0, 2'b10, 2'b01, 5'b00001, "R7 index 0 rx beats index 1 tx");
    rd(8'h4, 32'h100, "R7 bit 8 only");
    wr(8'h4, 32'h0);
    pulse(0, 2'b01, 2'b01, 5'b00100, "R8 tx beats rx");
    rd(8'h4, 32'h100, "R8 bit 8");
    wr(8'h4, 32'h0);
    pulse(0, 2'b10, 2'b00, 5'b01000, "R4 serial 1 ack");
    rd(8'h4, 32'h200, "R4 serial 1 bit 9");
    wr(8'h4, 32'h0);
  endtask

  task automatic t_blocked;
    wr(8'h4, 32'h100);
    pulse(0, 2'b10, 2'b01, 5'b00000, "R9 blocked winner no fallback");
    rd(8'h4, 32'h100, "R9 pend unchanged");
    wr(8'h4, 32'h0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h4; bus_wdata = 32'h1;
    tmr_req = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tmr_req = 0;
    rd(8'h4, 32'h9, "R11 event survives write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_record;
    t_prio;
    t_blocked;
    t_collide;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule